// File: doc/BRIEF.md
# Ticket Lock Unit

A hardware lock that serves a fixed set of requesters first come, first served. It keeps two counters. The dispense counter is the place in line that the next arrival receives. The serving counter is the ticket that currently owns the lock. An acquire takes the present dispense value as its ticket and advances the counter by one, all in a single indivisible step. The requester keeps its ticket and watches its grant line. The grant rises when the serving counter reaches the ticket. A release from the grant holder advances the serving counter, and the lock passes to the next ticket in line.

Each requester holds at most one ticket at a time. For every requester the unit shows how many positions stand between its ticket and the current owner. Software can use this distance to size its backoff. Acquires that arrive in the same cycle get consecutive tickets, ordered by requester index. A release from a requester that does not own the lock changes nothing, and it raises an error pulse for that requester.

Top module: `ticket_lock`

## Requirements
- R1: After reset both counters are 0, no requester holds a ticket, and no grant or error is raised.
- R2: An acquire (`acq_req[i]`) from a requester without a ticket stores the dispense value in slot i (`tkt_out[i*TKT_W +: TKT_W]`) and sets `tkt_valid[i]` one cycle later. The dispense counter advances by one for each accepted acquire.
- R3: `grant[i]` is high exactly while requester i holds a ticket equal to the serving counter, and at most one grant is high at any time.
- R4: A release (`rel_req[i]`) while `grant[i]` is high advances the serving counter by one and clears `tkt_valid[i]` one cycle later.
- R5: Grants are given in the order in which the tickets were taken.
- R6: `wait_dist[i*TKT_W +: TKT_W]` equals (ticket − serving counter) mod 2^TKT_W while requester i holds a ticket, and is 0 otherwise.
- R7: Acquires that arrive in the same cycle receive consecutive tickets, with the lower requester index taking the lower ticket.
- R8: A release from a requester whose grant is low leaves the counters and tickets unchanged, and it raises `rel_err[i]` for exactly the following cycle.
- R9: An acquire from a requester that already holds a ticket is ignored. Its ticket and the dispense counter do not change.
- R10: Both counters wrap modulo 2^TKT_W, and TKT_W is at least clog2(N_REQ)+1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| acq_req | input | N_REQ | Per-requester acquire pulse |
| rel_req | input | N_REQ | Per-requester release pulse |
| tkt_valid | output | N_REQ | Requester holds a ticket |
| tkt_out | output | N_REQ*TKT_W | Held ticket per requester, slot i at bits i*TKT_W |
| grant | output | N_REQ | Requester owns the lock |
| wait_dist | output | N_REQ*TKT_W | Distance from ticket to serving counter, per requester |
| next_tkt | output | TKT_W | Dispense counter |
| serve_tkt | output | TKT_W | Serving counter |
| rel_err | output | N_REQ | Release-without-ownership pulse |

## Verification
The embedded properties are checked on every cycle. They cover: at most one grant at a time; the dispense counter advancing by exactly the number of accepted acquires; the serving counter moving only on a legal release, and then by one; a wrongful release leaving the serving counter alone; a held ticket staying frozen; and a zero wait distance coinciding with the grant. First-come ordering across many cycles, consecutive tickets for simultaneous arrivals, and correct wraparound of both counters can only be shown by the bench scenarios. The bench follows a queue-based model of ticket order through long stretches of traffic.

// File: rtl/tkt_pkg.sv
`timescale 1ns/1ps
package tkt_pkg;

  // Number of set bits of vec strictly below position idx.
  function automatic int below_count(input logic [31:0] vec, input int idx);
    int c;
    c = 0;
    for (int k = 0; k < 32; k++) begin
      if (k < idx && vec[k]) c++;
    end
    return c;
  endfunction

  // Forward distance from b to a on a ring of 2^w positions.
  function automatic int ring_gap(input int a, input int b, input int w);
    return (a - b) & ((1 << w) - 1);
  endfunction

endpackage

// File: rtl/tkt_dispenser.sv
`timescale 1ns/1ps
module tkt_dispenser #(
  parameter int N_REQ = 4,
  parameter int TKT_W = 3
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [N_REQ-1:0]         take,
  output logic [TKT_W-1:0]         base_q,
  output logic [N_REQ*TKT_W-1:0]   tkt_for
);
  localparam int CNT_W = $clog2(N_REQ + 1);

  logic [CNT_W-1:0] n_take;

  always_comb n_take = CNT_W'($countones(take));

  for (genvar i = 0; i < N_REQ; i++) begin : g_off
    always_comb
      tkt_for[i*TKT_W +: TKT_W] = base_q + TKT_W'(tkt_pkg::below_count(32'(take), i));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) base_q <= '0;
    else        base_q <= base_q + TKT_W'(n_take);
  end

  // R2 / R10: counter moves by exactly the accepted acquires, modulo the ring
  p_next_adv_r2: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> base_q == TKT_W'($past(base_q) + TKT_W'($countones($past(take)))));

endmodule

// File: rtl/tkt_slot.sv
`timescale 1ns/1ps
module tkt_slot #(
  parameter int TKT_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             acq,
  input  logic             rel,
  input  logic [TKT_W-1:0] tkt_in,
  input  logic [TKT_W-1:0] serve,
  output logic             take,
  output logic             held_q,
  output logic             grant,
  output logic             clear,
  output logic [TKT_W-1:0] tkt_q,
  output logic [TKT_W-1:0] gap
);
  always_comb begin
    take  = acq & ~held_q;
    grant = held_q && (tkt_q == serve);
    clear = rel & grant;
    gap   = held_q ? TKT_W'(tkt_pkg::ring_gap(int'(tkt_q), int'(serve), TKT_W)) : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      held_q <= 1'b0;
      tkt_q  <= '0;
    end else if (take) begin
      held_q <= 1'b1;
      tkt_q  <= tkt_in;
    end else if (clear) begin
      held_q <= 1'b0;
    end
  end

  // R9: a held ticket is not replaced by a further acquire
  p_hold_frozen_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (held_q && acq && !clear) |=> (held_q && $stable(tkt_q)));

  // R4: a legal release frees the slot
  p_release_frees_r4: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> !held_q);

  // R6: zero distance coincides with ownership
  p_gap_grant_r6: assert property (@(posedge clk) disable iff (!rst_n)
    held_q |-> ((gap == '0) == grant));

endmodule

// File: rtl/tkt_owner.sv
`timescale 1ns/1ps
module tkt_owner #(
  parameter int N_REQ = 4,
  parameter int TKT_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_REQ-1:0] rel,
  input  logic [N_REQ-1:0] grant,
  output logic             rel_ok,
  output logic [TKT_W-1:0] serve_q,
  output logic [N_REQ-1:0] rel_err_q
);
  logic [N_REQ-1:0] bad;

  always_comb begin
    rel_ok = |(rel & grant);
    bad    = rel & ~grant;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      serve_q   <= '0;
      rel_err_q <= '0;
    end else begin
      serve_q   <= serve_q + {{(TKT_W-1){1'b0}}, rel_ok};
      rel_err_q <= bad;
    end
  end

  // R4: serving counter steps by one on a legal release
  p_serve_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
    rel_ok |=> serve_q == TKT_W'($past(serve_q) + 1'b1));

  // R8: a wrongful release alone moves nothing and is flagged
  p_bad_ignored_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!rel_ok && (|bad)) |=> ($stable(serve_q) && rel_err_q == $past(bad)));

endmodule

// File: rtl/ticket_lock.sv
`timescale 1ns/1ps
module ticket_lock #(
  parameter int N_REQ = 4,
  parameter int TKT_W = $clog2(N_REQ) + 1
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [N_REQ-1:0]       acq_req,
  input  logic [N_REQ-1:0]       rel_req,
  output logic [N_REQ-1:0]       tkt_valid,
  output logic [N_REQ*TKT_W-1:0] tkt_out,
  output logic [N_REQ-1:0]       grant,
  output logic [N_REQ*TKT_W-1:0] wait_dist,
  output logic [TKT_W-1:0]       next_tkt,
  output logic [TKT_W-1:0]       serve_tkt,
  output logic [N_REQ-1:0]       rel_err
);
  logic [N_REQ-1:0]       take_v;
  logic [N_REQ-1:0]       clear_v;
  logic [N_REQ*TKT_W-1:0] tkt_for;
  logic                   rel_ok;

  tkt_dispenser #(.N_REQ(N_REQ), .TKT_W(TKT_W)) u_disp (
    .clk(clk), .rst_n(rst_n), .take(take_v),
    .base_q(next_tkt), .tkt_for(tkt_for)
  );

  tkt_owner #(.N_REQ(N_REQ), .TKT_W(TKT_W)) u_own (
    .clk(clk), .rst_n(rst_n), .rel(rel_req), .grant(grant),
    .rel_ok(rel_ok), .serve_q(serve_tkt), .rel_err_q(rel_err)
  );

  for (genvar i = 0; i < N_REQ; i++) begin : g_slot
    tkt_slot #(.TKT_W(TKT_W)) u_slot (
      .clk(clk), .rst_n(rst_n),
      .acq(acq_req[i]), .rel(rel_req[i]),
      .tkt_in(tkt_for[i*TKT_W +: TKT_W]), .serve(serve_tkt),
      .take(take_v[i]), .held_q(tkt_valid[i]), .grant(grant[i]),
      .clear(clear_v[i]),
      .tkt_q(tkt_out[i*TKT_W +: TKT_W]), .gap(wait_dist[i*TKT_W +: TKT_W])
    );
  end

  // R3: single owner
  p_grant_onehot_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant));

  // R4: owner-side and slot-side views of a legal release agree
  p_release_agree_r4: assert property (@(posedge clk) disable iff (!rst_n)
    rel_ok == (|clear_v));

endmodule

// File: tb/tb_ticket_lock.sv
`timescale 1ns/1ps
module tb_ticket_lock;
  localparam int N = 4;
  localparam int W = 3;
  localparam int M = 1 << W;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [N-1:0] acq = '0;
  logic [N-1:0] rel = '0;
  logic [N-1:0] tkt_valid, grant, rel_err;
  logic [N*W-1:0] tkt_out, wait_dist;
  logic [W-1:0] next_tkt, serve_tkt;

  always #4 clk = ~clk;

  ticket_lock #(.N_REQ(N), .TKT_W(W)) dut (
    .clk(clk), .rst_n(rst_n), .acq_req(acq), .rel_req(rel),
    .tkt_valid(tkt_valid), .tkt_out(tkt_out), .grant(grant),
    .wait_dist(wait_dist), .next_tkt(next_tkt), .serve_tkt(serve_tkt),
    .rel_err(rel_err)
  );

  int n_run = 0;
  int n_fail = 0;
  bit done = 0;

  // behavioural model
  int m_tkt[N];
  bit m_held[N];
  bit m_err[N];
  int m_next, m_serve;
  int order_q[$];

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < N; i++) begin m_tkt[i] = 0; m_held[i] = 0; m_err[i] = 0; end
      m_next = 0; m_serve = 0;
      order_q.delete();
    end else begin
      bit was_held[N];
      bit freed;
      freed = 0;
      for (int i = 0; i < N; i++) was_held[i] = m_held[i];
      for (int i = 0; i < N; i++) begin
        m_err[i] = 0;
        if (rel[i]) begin
          if (m_held[i] && m_tkt[i] == m_serve) begin
            freed = 1; m_held[i] = 0;
          end else m_err[i] = 1;
        end
      end
      if (freed) begin
        m_serve = (m_serve + 1) % M;
        void'(order_q.pop_front());
      end
      for (int i = 0; i < N; i++) begin
        if (acq[i] && !was_held[i]) begin
          m_tkt[i] = m_next; m_held[i] = 1;
          m_next = (m_next + 1) % M;
          order_q.push_back(i);
        end
      end
    end
  end

  always @(negedge clk) begin
    if (rst_n && !done) begin
      for (int i = 0; i < N; i++) begin
        bit g;
        int gp;
        g = m_held[i] && (m_tkt[i] == m_serve);
        gp = m_held[i] ? ((m_tkt[i] - m_serve) & (M - 1)) : 0;
        chk(grant[i] == g, "R3 grant", int'(grant[i]), int'(g));
        chk(tkt_valid[i] == m_held[i], "R2 ticket valid", int'(tkt_valid[i]), int'(m_held[i]));
        if (m_held[i])
          chk(int'(tkt_out[i*W +: W]) == m_tkt[i], "R2 ticket value", int'(tkt_out[i*W +: W]), m_tkt[i]);
        chk(int'(wait_dist[i*W +: W]) == gp, "R6 wait distance", int'(wait_dist[i*W +: W]), gp);
        chk(rel_err[i] == m_err[i], "R8 release error", int'(rel_err[i]), int'(m_err[i]));
        if (grant[i])
          chk(order_q.size() > 0 && order_q[0] == i, "R5 fifo order", i,
              (order_q.size() > 0) ? order_q[0] : -1);
      end
      chk(int'(next_tkt) == m_next, "R10 dispense counter", int'(next_tkt), m_next);
      chk(int'(serve_tkt) == m_serve, "R4 serving counter", int'(serve_tkt), m_serve);
    end
  end

  task automatic pulse(input logic [N-1:0] a, input logic [N-1:0] r);
    @(negedge clk);
    acq = a; rel = r;
    @(posedge clk);
    #1;
    acq = '0; rel = '0;
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(next_tkt == '0 && serve_tkt == '0, "R1 counters", int'(next_tkt), 0);
    chk(tkt_valid == '0 && grant == '0 && rel_err == '0, "R1 flags", int'(tkt_valid | grant | rel_err), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // R7: simultaneous acquires by index order
    pulse(4'b1111, 4'b0000);
    @(negedge clk);
    for (int i = 0; i < N; i++)
      chk(int'(tkt_out[i*W +: W]) == i, "R7 consecutive ticket", int'(tkt_out[i*W +: W]), i);
    chk(grant == 4'b0001, "R3 first owner", int'(grant), 1);
    chk(int'(wait_dist[3*W +: W]) == 3, "R6 last in line", int'(wait_dist[3*W +: W]), 3);

    // R8: non-owner release
    pulse(4'b0000, 4'b0100);
    @(negedge clk);
    chk(rel_err == 4'b0100, "R8 error pulse", int'(rel_err), 4);
    chk(serve_tkt == '0 && tkt_valid == 4'b1111, "R8 no effect", int'(serve_tkt), 0);
    @(negedge clk);
    chk(rel_err == '0, "R8 single cycle", int'(rel_err), 0);

    // R9: acquire while holding
    pulse(4'b0010, 4'b0000);
    @(negedge clk);
    chk(int'(tkt_out[1*W +: W]) == 1 && int'(next_tkt) == 4, "R9 ignored", int'(next_tkt), 4);

    // R4 / R5: drain in order
    for (int k = 0; k < N; k++) begin
      pulse(4'(1 << k), 4'b0000 | 4'(1 << k));
      @(negedge clk);
      chk(int'(serve_tkt) == k + 1, "R4 serve step", int'(serve_tkt), k + 1);
    end

    // random traffic, wraps both counters
    for (int c = 0; c < 3000; c++) begin
      logic [N-1:0] a, r;
      @(negedge clk);
      a = N'($urandom & $urandom);
      r = '0;
      for (int i = 0; i < N; i++)
        if (m_held[i] && m_tkt[i] == m_serve && ($urandom % 3 != 0)) r[i] = 1'b1;
      if ($urandom % 12 == 0) r[$urandom % N] = 1'b1;
      acq = a; rel = r;
    end
    @(negedge clk);
    acq = '0; rel = '0;
    repeat (3) @(negedge clk);
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule